// File: doc/BRIEF.md
# Host Reader for a Self-Clocked Serial Converter

This block is the host-side controller for a converter that drives its own serial clock. The host never drives that clock line. It only lowers and raises chip select, watches the status flag the converter places on its data line, and samples the serial result on the clock edges the converter supplies. A 32-bit frame is received in one transfer. The first bit of the frame is the end-of-conversion flag. While the frame comes in, the host sends a configuration word back to the converter. The converter samples that word on its rising edges.

A request selects one of two modes. In wait mode, chip select is held low until the converter starts clocking. In poll mode, the host pulses chip select to test the flag and releases it before any clock edge while the converter is still busy. It keeps chip select low once the flag reads zero. An optional bit count ends the transfer early, which also restarts conversion in the converter. The host keeps a shadow copy of the configuration the converter has actually accepted. The converter and host clocks are unrelated, so the incoming clock and data are synchronized into the system clock domain. Edges are detected there. The finished word is returned with a one-cycle strobe and a flag that marks a partial read.

Top module: `adc_selfclk_reader`

## Requirements
- R1: After reset, chip select is high, busy, valid and error are low, and the configuration shadow equals the reset parameter value.
- R2: In wait mode (rd_mode=0), chip select falls once after a request and stays low until the transfer ends. The 32 bits are captured MSB-first on converter rising edges, so the status flag (0 for a ready result) lands in rd_data[31].
- R3: In poll mode (rd_mode=1), chip select is lowered for a status test. If the flag reads 1, chip select is raised again before any rising clock edge and the test is retried after a gap. Once the flag reads 0, chip select stays low and the frame is read.
- R4: The configuration word goes out MSB-first on cnv_sdi. Its first bit is present before the first rising edge, and each later bit changes only after a falling edge that follows a rising edge.
- R5: The shadow cfg_active takes the sent word only once CFG_W rising edges have occurred in the transfer. A transfer ended earlier leaves the previous value.
- R6: abort_bits=N with 1<=N<=31 ends the transfer after the Nth rising edge. rd_data then holds the N received bits in its low N positions, the earliest bit at position N-1 and zeros above, and rd_partial=1. N=0 or N>=32 reads all 32 bits with rd_partial=0.
- R7: Each finished read, whole or partial, raises rd_valid for exactly one cycle, in the same cycle that rd_data and rd_partial are valid.
- R8: If no converter clock edge arrives for TMO_CYC cycles during a transfer, tmo_err pulses for one cycle, chip select goes high and no rd_valid is produced.
- R9: During a transfer, chip select is raised only while the synchronized converter clock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Start a read (accepted while not busy) |
| rd_mode | input | 1 | 0 = wait mode, 1 = poll mode |
| cfg_word | input | CFG_W | Configuration word to send during the transfer |
| abort_bits | input | 6 | Rising edges before early stop; 0 or >=32 means full frame |
| rd_busy | output | 1 | A read is in progress |
| rd_valid | output | 1 | One-cycle strobe: rd_data is valid |
| rd_data | output | 32 | Received frame, right-aligned when partial |
| rd_partial | output | 1 | The read was stopped early |
| tmo_err | output | 1 | One-cycle pulse: converter clock timed out |
| cfg_active | output | CFG_W | Configuration last accepted by the converter |
| cnv_cs_n | output | 1 | Chip select to the converter, active low |
| cnv_sclk | input | 1 | Serial clock driven by the converter |
| cnv_sdo | input | 1 | Serial data and status flag from the converter |
| cnv_sdi | output | 1 | Serial configuration data to the converter |

## Verification
An early stop and the update of the configuration shadow can fall on the same rising edge. This happens when the abort count equals the configuration width. The bench provokes it by requesting a read with abort_bits equal to CFG_W. A behavioural converter model then records how many rising edges it produced and which configuration it accepted. The verdict is that rd_partial is set, exactly CFG_W bits arrive right-aligned, the shadow takes the new word, and chip select never rises while the model holds its clock low.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    // Bits in one converter frame, status flag included.
    localparam int unsigned FRAME_BITS = 32;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_GAP,
        ST_XFER,
        ST_DONE
    } rd_state_e;

    typedef enum logic {
        MODE_WAIT = 1'b0,
        MODE_POLL = 1'b1
    } rd_mode_e;

    // Edge events of the synchronized converter clock.
    typedef struct packed {
        logic rise;
        logic fall;
    } clk_evt_t;

    // Rising-edge count at which a transfer stops.
    function automatic logic [CNT_W-1:0] stop_count(input logic [CNT_W-1:0] req_bits);
        if (req_bits == '0 || req_bits >= CNT_W'(FRAME_BITS)) begin
            return CNT_W'(FRAME_BITS);
        end
        return req_bits;
    endfunction

endpackage

// File: rtl/adcr_sync.sv
module adcr_sync
    import adcr_pkg::*;
#(
    parameter int unsigned W       = 2,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output clk_evt_t     evt
);

    logic [STAGES-1:0][W-1:0] pipe;
    logic                     prev0;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) pipe[0] <= RST_VAL;
                    else     pipe[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) pipe[s] <= RST_VAL;
                    else     pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev0 <= RST_VAL[0];
        else     prev0 <= pipe[STAGES-1][0];
    end

    assign q        = pipe[STAGES-1];
    assign evt.rise = q[0] & ~prev0;
    assign evt.fall = ~q[0] & prev0;

endmodule

// File: rtl/adcr_serdes.sv
module adcr_serdes
    import adcr_pkg::*;
#(
    parameter int unsigned      CFG_W   = 8,
    parameter logic [CFG_W-1:0] CFG_RST = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [CFG_W-1:0]      cfg_in,
    input  logic                  active,
    input  clk_evt_t              evt,
    input  logic                  sdo_lvl,
    output logic                  sdi,
    output logic [CNT_W-1:0]      rcnt,
    output logic [FRAME_BITS-1:0] word,
    output logic [CFG_W-1:0]      shadow
);

    logic [CFG_W-1:0] cfg_sr;
    logic [CFG_W-1:0] cfg_hold;
    logic             take_bit;
    logic             next_bit;

    assign take_bit = active && evt.rise;
    assign next_bit = active && evt.fall && (rcnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_sr   <= '0;
            cfg_hold <= CFG_RST;
            shadow   <= CFG_RST;
            word     <= '0;
            rcnt     <= '0;
        end else if (load) begin
            cfg_sr   <= cfg_in;
            cfg_hold <= cfg_in;
            word     <= '0;
            rcnt     <= '0;
        end else begin
            if (take_bit) begin
                word <= {word[FRAME_BITS-2:0], sdo_lvl};
                rcnt <= rcnt + CNT_W'(1);
                if (rcnt + CNT_W'(1) == CNT_W'(CFG_W)) begin
                    shadow <= cfg_hold;
                end
            end
            if (next_bit) begin
                cfg_sr <= {cfg_sr[CFG_W-2:0], 1'b0};
            end
        end
    end

    assign sdi = cfg_sr[CFG_W-1];

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(active && evt.rise) |=> $stable(shadow)) else $error("shadow moved without edge"); // R5

    AST_SDI_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        !(evt.fall || load) |=> $stable(sdi)) else $error("sdi changed off a falling edge"); // R4

    AST_RCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        rcnt <= CNT_W'(FRAME_BITS)) else $error("edge count overran frame"); // R6

endmodule

// File: rtl/adcr_timeout.sv
module adcr_timeout #(
    parameter int unsigned TMO_CYC = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic kick,
    output logic expired
);

    localparam int unsigned TW = $clog2(TMO_CYC + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || kick) begin
            cnt <= '0;
        end else if (cnt != TW'(TMO_CYC)) begin
            cnt <= cnt + TW'(1);
        end
    end

    assign expired = run && (cnt == TW'(TMO_CYC));

    AST_TMO_SAT: assert property (@(posedge clk) disable iff (rst)
        cnt <= TW'(TMO_CYC)) else $error("timeout counter overran"); // R8

endmodule

// File: rtl/adcr_ctrl.sv
module adcr_ctrl
    import adcr_pkg::*;
#(
    parameter int unsigned STS_WAIT = 6,
    parameter int unsigned POLL_GAP = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             mode,
    input  logic [CNT_W-1:0] abort_bits,
    input  logic             sdo_lvl,
    input  logic             sclk_lvl,
    input  clk_evt_t         evt,
    input  logic [CNT_W-1:0] rcnt,
    input  logic             expired,
    output logic             cs_n,
    output logic             load,
    output logic             active,
    output logic             busy,
    output logic             rd_valid,
    output logic             rd_partial,
    output logic             tmo_err
);

    localparam int unsigned WMAX   = (STS_WAIT > POLL_GAP) ? STS_WAIT : POLL_GAP;
    localparam int unsigned WAIT_W = $clog2(WMAX + 1);

    rd_state_e        state, nxt;
    logic [WAIT_W-1:0] wcnt;
    logic [CNT_W-1:0]  stop_q;
    logic              hit;
    rd_mode_e          mode_e;

    assign mode_e = rd_mode_e'(mode);
    assign hit    = evt.rise && (rcnt + CNT_W'(1) == stop_q);

    always_comb begin
        nxt  = state;
        load = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req) begin
                    load = 1'b1;
                    nxt  = (mode_e == MODE_POLL) ? ST_CHECK : ST_XFER;
                end
            end
            ST_CHECK: begin
                if (wcnt == WAIT_W'(STS_WAIT - 1)) begin
                    nxt = sdo_lvl ? ST_GAP : ST_XFER;
                end
            end
            ST_GAP: begin
                if (wcnt == WAIT_W'(POLL_GAP - 1)) begin
                    nxt = ST_CHECK;
                end
            end
            ST_XFER: begin
                if (expired)  nxt = ST_IDLE;
                else if (hit) nxt = ST_DONE;
            end
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            wcnt       <= '0;
            cs_n       <= 1'b1;
            stop_q     <= CNT_W'(FRAME_BITS);
            rd_partial <= 1'b0;
            tmo_err    <= 1'b0;
        end else begin
            state   <= nxt;
            wcnt    <= (nxt != state) ? '0 : wcnt + WAIT_W'(1);
            cs_n    <= !(nxt == ST_CHECK || nxt == ST_XFER);
            tmo_err <= (state == ST_XFER) && expired;
            if (state == ST_IDLE && req) begin
                stop_q <= stop_count(abort_bits);
            end
            if (state == ST_XFER && nxt == ST_DONE) begin
                rd_partial <= (stop_q != CNT_W'(FRAME_BITS));
            end
        end
    end

    assign active   = (state == ST_XFER);
    assign busy     = (state != ST_IDLE);
    assign rd_valid = (state == ST_DONE);

    AST_CS_ABORT_HIGH: assert property (@(posedge clk) disable iff (rst)
        ($rose(cs_n) && $past(state) == ST_XFER && !tmo_err) |-> $past(sclk_lvl))
        else $error("chip select raised with clock low"); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid) else $error("valid longer than one cycle"); // R7

    AST_IDLE_CS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> cs_n) else $error("chip select low while idle"); // R1

    AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> (!rd_valid && cs_n)) else $error("timeout with valid or cs low"); // R8

    AST_POLL_GAP_CS: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |-> cs_n) else $error("chip select low in poll gap"); // R3

endmodule

// File: rtl/adc_selfclk_reader.sv
module adc_selfclk_reader
    import adcr_pkg::*;
#(
    parameter int unsigned      CFG_W       = 8,
    parameter logic [CFG_W-1:0] CFG_RST     = '0,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter int unsigned      STS_WAIT    = 6,
    parameter int unsigned      POLL_GAP    = 8,
    parameter int unsigned      TMO_CYC     = 4096
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_req,
    input  logic                  rd_mode,
    input  logic [CFG_W-1:0]      cfg_word,
    input  logic [CNT_W-1:0]      abort_bits,
    output logic                  rd_busy,
    output logic                  rd_valid,
    output logic [FRAME_BITS-1:0] rd_data,
    output logic                  rd_partial,
    output logic                  tmo_err,
    output logic [CFG_W-1:0]      cfg_active,
    output logic                  cnv_cs_n,
    input  logic                  cnv_sclk,
    input  logic                  cnv_sdo,
    output logic                  cnv_sdi
);

    logic [1:0]       pins_s;
    clk_evt_t         sclk_evt;
    logic             load;
    logic             active;
    logic             expired;
    logic [CNT_W-1:0] rcnt;

    adcr_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cnv_sdo, cnv_sclk}),
        .q   (pins_s),
        .evt (sclk_evt)
    );

    adcr_ctrl #(
        .STS_WAIT (STS_WAIT),
        .POLL_GAP (POLL_GAP)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (rd_req),
        .mode       (rd_mode),
        .abort_bits (abort_bits),
        .sdo_lvl    (pins_s[1]),
        .sclk_lvl   (pins_s[0]),
        .evt        (sclk_evt),
        .rcnt       (rcnt),
        .expired    (expired),
        .cs_n       (cnv_cs_n),
        .load       (load),
        .active     (active),
        .busy       (rd_busy),
        .rd_valid   (rd_valid),
        .rd_partial (rd_partial),
        .tmo_err    (tmo_err)
    );

    adcr_serdes #(
        .CFG_W   (CFG_W),
        .CFG_RST (CFG_RST)
    ) u_serdes (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .cfg_in  (cfg_word),
        .active  (active),
        .evt     (sclk_evt),
        .sdo_lvl (pins_s[1]),
        .sdi     (cnv_sdi),
        .rcnt    (rcnt),
        .word    (rd_data),
        .shadow  (cfg_active)
    );

    adcr_timeout #(
        .TMO_CYC (TMO_CYC)
    ) u_tmo (
        .clk     (clk),
        .rst     (rst),
        .run     (active),
        .kick    (sclk_evt.rise | sclk_evt.fall),
        .expired (expired)
    );

    initial begin
        AST_CFG_FITS: assert (CFG_W >= 2 && CFG_W <= FRAME_BITS) else $error("CFG_W out of range"); // R5
    end

endmodule

// File: tb/tb_adc_selfclk_reader.sv
module tb_adc_selfclk_reader;
    import adcr_pkg::*;

    localparam int CFG_W   = 8;
    localparam logic [CFG_W-1:0] CFG_RST = 8'h3C;
    localparam int HALF    = 6;
    localparam int T_START = 20;

    logic clk = 0;
    logic rst = 1;
    always #2.5 clk = ~clk;

    logic             rd_req = 0, rd_mode = 0;
    logic [CFG_W-1:0] cfg_word = '0;
    logic [CNT_W-1:0] abort_bits = '0;
    logic             rd_busy, rd_valid, rd_partial, tmo_err, cs_n, cnv_sdi;
    logic [31:0]      rd_data;
    logic [CFG_W-1:0] cfg_active;
    logic             m_sclk = 1, m_sdo = 1;

    adc_selfclk_reader #(.CFG_W(CFG_W), .CFG_RST(CFG_RST), .TMO_CYC(300)) dut (
        .clk(clk), .rst(rst), .rd_req(rd_req), .rd_mode(rd_mode), .cfg_word(cfg_word),
        .abort_bits(abort_bits), .rd_busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_partial(rd_partial), .tmo_err(tmo_err), .cfg_active(cfg_active),
        .cnv_cs_n(cs_n), .cnv_sclk(m_sclk), .cnv_sdo(m_sdo), .cnv_sdi(cnv_sdi)
    );

    int checks = 0, fails = 0;
    int cv_done = 0, m_frames = 0, m_rises = 0, m_low_abort = 0;
    logic [30:0] m_word = '0;
    logic [31:0] m_sdi_sr = '0;
    logic [CFG_W-1:0] m_cfg_acc = CFG_RST;
    logic m_ready;
    assign m_ready = (cv_done > m_frames);

    // Behavioural converter: drives its own clock, samples cnv_sdi on rises.
    initial begin : conv_model
        forever begin
            @(negedge clk);
            if (cs_n == 1'b0) begin
                logic [31:0] frame;
                bit ab;
                int n;
                m_sclk = 0;
                m_sdo  = ~m_ready;
                while (!m_ready && !cs_n) @(negedge clk);
                if (!cs_n) begin
                    m_sdo = 0;
                    n = 0;
                    while (n < T_START && !cs_n) begin @(negedge clk); n++; end
                    if (!cs_n) begin
                        frame = {1'b0, m_word};
                        ab = 0;
                        m_rises = 0;
                        for (int b = 0; b < 32 && !ab; b++) begin
                            m_sclk = 1;
                            m_sdi_sr = {m_sdi_sr[30:0], cnv_sdi};
                            m_rises++;
                            if (m_rises == CFG_W) m_cfg_acc = m_sdi_sr[CFG_W-1:0];
                            for (int h = 0; h < HALF && !ab; h++) begin
                                @(negedge clk);
                                if (cs_n) ab = 1;
                            end
                            if (!ab && b < 31) begin
                                m_sclk = 0;
                                m_sdo  = frame[30-b];
                                for (int h = 0; h < HALF && !ab; h++) begin
                                    @(negedge clk);
                                    if (cs_n) begin ab = 1; m_low_abort++; end
                                end
                            end
                        end
                        m_sdo = 1;
                        while (!cs_n) @(negedge clk);
                        m_frames++;
                    end
                end
                m_sclk = 1;
                m_sdo  = 1;
            end
        end
    end

    // Output monitor, sampled mid-cycle.
    int vcnt = 0, ecnt = 0, csfall = 0;
    logic cs_prev = 1;
    logic [31:0] last_data = '0;
    logic last_part = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin vcnt++; last_data = rd_data; last_part = rd_partial; end
            if (tmo_err) ecnt++;
            if (cs_prev && !cs_n) csfall++;
            cs_prev = cs_n;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic mode, input logic [CFG_W-1:0] cfg, input logic [CNT_W-1:0] nab);
        @(negedge clk);
        rd_mode = mode; cfg_word = cfg; abort_bits = nab; rd_req = 1;
        @(negedge clk);
        rd_req = 0;
    endtask

    task automatic wait_valid(input int v0);
        int k = 0;
        while (vcnt == v0 && k < 3000) begin @(negedge clk); k++; end
        repeat (6) @(negedge clk);
    endtask

    logic [CFG_W-1:0] exp_shadow = CFG_RST;

    task automatic t_reset;
        chk(cs_n == 1'b1, "R1 cs_n", 32'(cs_n), 1);
        chk(!rd_busy && !rd_valid && !tmo_err, "R1 flags", {29'b0, rd_busy, rd_valid, tmo_err}, 0);
        chk(cfg_active == CFG_RST, "R1 shadow", 32'(cfg_active), 32'(CFG_RST));
    endtask

    task automatic t_wait_full(input logic [CFG_W-1:0] cfg, input logic [30:0] w);
        int v0 = vcnt, c0 = csfall;
        m_word = w;
        issue(1'b0, cfg, '0);
        repeat (30) @(negedge clk);
        cv_done++;
        wait_valid(v0);
        exp_shadow = cfg;
        chk(last_data == {1'b0, w}, "R2 data", last_data, {1'b0, w});
        chk(last_data[31] == 1'b0, "R2 flag bit", 32'(last_data[31]), 0);
        chk(csfall - c0 == 1, "R2 single cs low", csfall - c0, 1);
        chk(last_part == 1'b0, "R6 full not partial", 32'(last_part), 0);
        chk(vcnt - v0 == 1, "R7 one valid cycle", vcnt - v0, 1);
        chk(m_cfg_acc == cfg, "R4 cfg received", 32'(m_cfg_acc), 32'(cfg));
        chk(cfg_active == exp_shadow, "R5 shadow full", 32'(cfg_active), 32'(exp_shadow));
        chk(m_rises == 32, "R2 32 rises", m_rises, 32);
    endtask

    task automatic t_poll(input logic [CFG_W-1:0] cfg, input logic [30:0] w);
        int v0 = vcnt, c0 = csfall, f0 = m_frames;
        m_word = w;
        issue(1'b1, cfg, '0);
        repeat (70) @(negedge clk);
        chk(m_frames == f0 && vcnt == v0, "R3 no transfer while busy", m_frames - f0, 0);
        chk(csfall - c0 >= 3, "R3 repeated status tests", csfall - c0, 3);
        cv_done++;
        wait_valid(v0);
        exp_shadow = cfg;
        chk(last_data == {1'b0, w}, "R3 data after poll", last_data, {1'b0, w});
        chk(cfg_active == exp_shadow, "R4 cfg after poll", 32'(cfg_active), 32'(exp_shadow));
    endtask

    task automatic t_abort(input int n, input logic [CFG_W-1:0] cfg, input logic [30:0] w);
        int v0 = vcnt, la0 = m_low_abort;
        logic [31:0] fr = {1'b0, w};
        logic [31:0] exp_d = fr >> (32 - n);
        m_word = w;
        cv_done++;
        issue(1'b0, cfg, CNT_W'(n));
        wait_valid(v0);
        if (n >= CFG_W) exp_shadow = cfg;
        chk(last_part == 1'b1, "R6 partial flag", 32'(last_part), 1);
        chk(last_data == exp_d, "R6 partial data", last_data, exp_d);
        chk(m_rises == n, "R6 edge count", m_rises, n);
        chk(cfg_active == exp_shadow, "R5 shadow after abort", 32'(cfg_active), 32'(exp_shadow));
        chk(m_low_abort == la0, "R9 cs raised with clock low", m_low_abort - la0, 0);
        chk(vcnt - v0 == 1, "R7 valid once on abort", vcnt - v0, 1);
    endtask

    task automatic t_big_count(input logic [CFG_W-1:0] cfg, input logic [30:0] w);
        int v0 = vcnt;
        m_word = w;
        cv_done++;
        issue(1'b0, cfg, CNT_W'(40));
        wait_valid(v0);
        exp_shadow = cfg;
        chk(last_part == 1'b0 && last_data == {1'b0, w}, "R6 count over frame reads all",
            last_data, {1'b0, w});
    endtask

    task automatic t_timeout;
        int v0 = vcnt, e0 = ecnt, k = 0;
        issue(1'b0, 8'hFF, '0);
        while (ecnt == e0 && k < 2000) begin @(negedge clk); k++; end
        repeat (4) @(negedge clk);
        chk(ecnt - e0 == 1, "R8 timeout pulse", ecnt - e0, 1);
        chk(vcnt == v0, "R8 no valid", vcnt - v0, 0);
        chk(cs_n == 1'b1 && !rd_busy, "R8 released", {30'b0, cs_n, rd_busy}, 2);
        chk(cfg_active == exp_shadow, "R5 shadow kept on timeout", 32'(cfg_active), 32'(exp_shadow));
    endtask

    bit finished = 0;
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=expired expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (5) @(negedge clk);
        t_reset();
        rst = 0;
        repeat (3) @(negedge clk);
        t_reset();
        t_wait_full(8'hB2, 31'h2D5A_1E77);
        t_poll(8'h61, 31'h7F00_13C5);
        t_abort(5, 8'h9E, 31'h4A6B_2C1D);
        t_abort(CFG_W, 8'hC7, 31'h1234_5678);
        t_abort(20, 8'h0F, 31'h6E3A_9B51);
        t_big_count(8'h5A, 31'h0F0F_3333);
        t_timeout();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule